// File: doc/BRIEF.md
# Rectangle Descriptor Table Refill Engine

This block rewrites entries of a two-dimensional address translation table from a chain of descriptors kept in memory. Software first checks that the engine is idle, then writes the byte address of the first descriptor to the start register. The engine fetches that descriptor, expands its rectangle into one table write per slot, and follows the next pointer until it reads a next pointer of zero.

Each descriptor is five 32-bit words, fetched in ascending address order. Word 0 holds the top-left corner, with x in bits [COORD_W-1:0] and y in bits [16+COORD_W-1:16]. Word 1 holds the bottom-right corner in the same packing. Word 2 is a control word whose bits [LUT_ID_W-1:0] select the target table. Word 3 points to the array of page addresses, one word per slot. Word 4 is the next pointer. Descriptor and data pointers must sit on 16-byte boundaries; a violation sets the error status and stops the walk.

On completion the engine raises a sticky interrupt status bit and a one-cycle interrupt pulse. Writing zero to the start register abandons any walk in progress.

Top module: `lut_refill_engine`

## Requirements
- R1: After reset the status register reads ready=1 and error=0, the interrupt status bit reads 0, and no memory request or table write is active.
- R2: A non-zero, 16-byte-aligned write to the start register (select 0) while ready clears the error and drops ready. The engine then reads the five descriptor words at D, D+4, D+8, D+12 and D+16 in that order.
- R3: A descriptor with corners (x0,y0) and (x1,y1) produces exactly (x1-x0+1)*(y1-y0+1) table writes in row-major order (x fastest). Write n has table address {y[COORD_W-1:0], x[COORD_W-1:0]}, data equal to the memory word at data pointer + 4n, and table id equal to control word bits [LUT_ID_W-1:0].
- R4: The engine follows next pointers until one reads zero. Only after the last write of that descriptor does ready return to 1, the interrupt status bit set, and irq_o pulse high for exactly one cycle.
- R5: A start address with any of bits [3:0] set sets error=1, keeps ready=1, and causes no memory read, no table write and no interrupt.
- R6: A data pointer or non-zero next pointer with any of bits [3:0] set sets error=1 and returns ready to 1 without an interrupt. Writes already made for earlier slots stay; no further write follows.
- R7: A descriptor with x1<x0 or y1<y0 sets error=1 and causes no table write.
- R8: Writing zero to the start register aborts any walk at once: no further table write or interrupt follows, and the status reads ready=1, error=0.
- R9: A non-zero start write while the engine is busy is ignored: the walk in progress and the recorded start address are unchanged.
- R10: Writing a 1 to bit 0 of the interrupt status register (select 2) clears that bit; writing 0 leaves it set.
- R11: Reads return, by select: 0 gives the last start address accepted while ready; 1 gives the status with ready in bit 0 and error in bit 1; 2 gives the interrupt status in bit 0; 3 gives zero.
- R12: A memory request keeps its address stable until the cycle in which mem_rvalid_i is seen, and every request address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | ADDR_W | Register write data |
| reg_rdata_o | output | ADDR_W | Register read data for reg_sel_i |
| irq_o | output | 1 | One-cycle pulse at list completion |
| mem_req_o | output | 1 | Memory read request, held until data returns |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_rvalid_i | input | 1 | Read data valid, one cycle per request |
| mem_rdata_i | input | DATA_W | Read data |
| lut_we_o | output | 1 | Table write strobe |
| lut_id_o | output | LUT_ID_W | Target table id |
| lut_addr_o | output | 2*COORD_W | Table entry address {y,x} |
| lut_data_o | output | DATA_W | Page address written into the entry |

## Verification
On every cycle, assertions check the memory handshake (address held while a request waits, word alignment) and confirm that each table write follows a returned read word. They also check that the completion pulse lasts one cycle, that an abort silences the engine on the next cycle, that the interrupt bit clears only through a write-one, that a start while busy leaves the recorded address alone, and that the slot walker stays inside its rectangle. Only the bench scenarios can show the full write sequence: addresses, data and table id in row-major order across sizes and chained descriptors, plus the exact point where a misaligned or inverted descriptor stops the walk and what an abort leaves behind.

// File: rtl/lre_pkg.sv
`timescale 1ns/1ps
package lre_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DESC, ST_SLOT} walk_state_e;

  localparam logic [1:0] SEL_START  = 2'd0;
  localparam logic [1:0] SEL_STATUS = 2'd1;
  localparam logic [1:0] SEL_IRQ    = 2'd2;

  localparam int          DESC_WORDS = 5;
  localparam int          WIDX_W     = 3;
  localparam logic [2:0]  W_CORNER0  = 3'd0;
  localparam logic [2:0]  W_CORNER1  = 3'd1;
  localparam logic [2:0]  W_CTRL     = 3'd2;
  localparam logic [2:0]  W_DATA     = 3'd3;
  localparam logic [2:0]  W_NEXT     = 3'd4;
  localparam int          Y_LSB      = 16;
endpackage

// File: rtl/lre_slot_gen.sv
`timescale 1ns/1ps
module lre_slot_gen #(
  parameter int COORD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [COORD_W-1:0] x0_i,
  input  logic [COORD_W-1:0] y0_i,
  input  logic [COORD_W-1:0] x1_i,
  input  logic [COORD_W-1:0] y1_i,
  input  logic               step_i,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o,
  output logic               last_o
);
  logic [COORD_W-1:0] x_q, y_q, x0_q, x1_q, y1_q;
  logic               active_q;
  logic               row_end;

  assign row_end = (x_q == x1_q);
  assign last_o  = row_end && (y_q == y1_q);
  assign x_o     = x_q;
  assign y_o     = y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q      <= '0;
      y_q      <= '0;
      x0_q     <= '0;
      x1_q     <= '0;
      y1_q     <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      x_q      <= x0_i;
      y_q      <= y0_i;
      x0_q     <= x0_i;
      x1_q     <= x1_i;
      y1_q     <= y1_i;
      active_q <= 1'b1;
    end else if (step_i) begin
      if (last_o) begin
        active_q <= 1'b0;
      end else if (row_end) begin
        x_q <= x0_q;
        y_q <= y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  // row-major walk never leaves the loaded rectangle
  p_in_rect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (x_q >= x0_q) && (x_q <= x1_q) && (y_q <= y1_q));
endmodule

// File: rtl/lre_walker.sv
`timescale 1ns/1ps
module lre_walker
  import lre_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int COORD_W    = 8,
  parameter int LUT_ID_W   = 2,
  parameter int ALIGN_BITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  abort_i,
  input  logic [ADDR_W-1:0]     start_addr_i,
  output logic                  busy_o,
  output logic                  error_o,
  output logic                  done_o,
  output logic                  mem_req_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  input  logic                  mem_rvalid_i,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic                  lut_we_o,
  output logic [LUT_ID_W-1:0]   lut_id_o,
  output logic [2*COORD_W-1:0]  lut_addr_o,
  output logic [DATA_W-1:0]     lut_data_o
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  walk_state_e          state_q;
  logic [WIDX_W-1:0]    widx_q;
  logic [ADDR_W-1:0]    addr_q, dptr_q, next_q;
  logic                 req_q, err_q, done_q;
  logic [COORD_W-1:0]   x0_q, y0_q, x1_q, y1_q;
  logic [LUT_ID_W-1:0]  id_q;
  logic                 we_q;
  logic [LUT_ID_W-1:0]  wid_q;
  logic [2*COORD_W-1:0] waddr_q;
  logic [DATA_W-1:0]    wdata_q;

  logic               bad_desc, sg_load, sg_step, sg_last;
  logic [COORD_W-1:0] sg_x, sg_y;

  function automatic logic misaligned(input logic [ADDR_W-1:0] a);
    return |a[ALIGN_BITS-1:0];
  endfunction

  assign bad_desc = misaligned(dptr_q) || (x1_q < x0_q) || (y1_q < y0_q);
  assign sg_load  = (state_q == ST_DESC) && mem_rvalid_i && (widx_q == W_NEXT)
                    && !abort_i && !bad_desc;
  assign sg_step  = (state_q == ST_SLOT) && mem_rvalid_i && !abort_i;

  lre_slot_gen #(.COORD_W(COORD_W)) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sg_load),
    .x0_i   (x0_q),
    .y0_i   (y0_q),
    .x1_i   (x1_q),
    .y1_i   (y1_q),
    .step_i (sg_step),
    .x_o    (sg_x),
    .y_o    (sg_y),
    .last_o (sg_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      addr_q  <= '0;
      dptr_q  <= '0;
      next_q  <= '0;
      req_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      x0_q    <= '0;
      y0_q    <= '0;
      x1_q    <= '0;
      y1_q    <= '0;
      id_q    <= '0;
      we_q    <= 1'b0;
      wid_q   <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      if (abort_i) begin
        state_q <= ST_IDLE;
        req_q   <= 1'b0;
        err_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (start_i) begin
              if (misaligned(start_addr_i)) begin
                err_q <= 1'b1;
              end else begin
                err_q   <= 1'b0;
                state_q <= ST_DESC;
                widx_q  <= '0;
                addr_q  <= start_addr_i;
                req_q   <= 1'b1;
              end
            end
          end
          ST_DESC: begin
            if (mem_rvalid_i) begin
              case (widx_q)
                W_CORNER0: begin
                  x0_q <= mem_rdata_i[COORD_W-1:0];
                  y0_q <= mem_rdata_i[Y_LSB +: COORD_W];
                end
                W_CORNER1: begin
                  x1_q <= mem_rdata_i[COORD_W-1:0];
                  y1_q <= mem_rdata_i[Y_LSB +: COORD_W];
                end
                W_CTRL:  id_q   <= mem_rdata_i[LUT_ID_W-1:0];
                W_DATA:  dptr_q <= mem_rdata_i[ADDR_W-1:0];
                default: next_q <= mem_rdata_i[ADDR_W-1:0];
              endcase
              if (widx_q != W_NEXT) begin
                widx_q <= widx_q + 1'b1;
                addr_q <= addr_q + WORD_STEP;
              end else if (bad_desc) begin
                err_q   <= 1'b1;
                state_q <= ST_IDLE;
                req_q   <= 1'b0;
              end else begin
                state_q <= ST_SLOT;
                addr_q  <= dptr_q;
              end
            end
          end
          ST_SLOT: begin
            if (mem_rvalid_i) begin
              we_q    <= 1'b1;
              wid_q   <= id_q;
              waddr_q <= {sg_y, sg_x};
              wdata_q <= mem_rdata_i;
              if (sg_last) begin
                if (next_q == '0) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
                  req_q   <= 1'b0;
                end else if (misaligned(next_q)) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
                  req_q   <= 1'b0;
                end else begin
                  state_q <= ST_DESC;
                  widx_q  <= '0;
                  addr_q  <= next_q;
                end
              end else begin
                addr_q <= addr_q + WORD_STEP;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign error_o    = err_q;
  assign done_o     = done_q;
  assign mem_req_o  = req_q;
  assign mem_addr_o = addr_q;
  assign lut_we_o   = we_q;
  assign lut_id_o   = wid_q;
  assign lut_addr_o = waddr_q;
  assign lut_data_o = wdata_q;

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i && !abort_i |=> mem_req_o && $stable(mem_addr_o));
  p_word_align_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
  p_write_after_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lut_we_o |-> $past(mem_rvalid_i));
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_abort_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !lut_we_o && !mem_req_o && !error_o && !done_o);
endmodule

// File: rtl/lre_regs.sv
`timescale 1ns/1ps
module lre_regs
  import lre_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  input  logic              ready_i,
  input  logic              error_i,
  input  logic              done_i,
  output logic              start_o,
  output logic              abort_o
);
  logic [ADDR_W-1:0] desc_q;
  logic              irq_q;
  logic              wr_start, wr_irq;

  assign wr_start = reg_wr_i && (reg_sel_i == SEL_START);
  assign wr_irq   = reg_wr_i && (reg_sel_i == SEL_IRQ);
  assign start_o  = wr_start && (|reg_wdata_i);
  assign abort_o  = wr_start && !(|reg_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (start_o && ready_i) desc_q <= reg_wdata_i;
      if (done_i)                     irq_q <= 1'b1;
      else if (wr_irq && reg_wdata_i[0]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      SEL_START:  reg_rdata_o = desc_q;
      SEL_STATUS: reg_rdata_o = {{(ADDR_W-2){1'b0}}, error_i, ready_i};
      SEL_IRQ:    reg_rdata_o = {{(ADDR_W-1){1'b0}}, irq_q};
      default:    reg_rdata_o = '0;
    endcase
  end

  p_ignore_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && !ready_i |=> $stable(desc_q));
  p_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> $past(wr_irq && reg_wdata_i[0]));
  p_irq_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> irq_q);
endmodule

// File: rtl/lut_refill_engine.sv
`timescale 1ns/1ps
module lut_refill_engine #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int COORD_W    = 8,
  parameter int LUT_ID_W   = 2,
  parameter int ALIGN_BITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic [1:0]           reg_sel_i,
  input  logic [ADDR_W-1:0]    reg_wdata_i,
  output logic [ADDR_W-1:0]    reg_rdata_o,
  output logic                 irq_o,
  output logic                 mem_req_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic                 mem_rvalid_i,
  input  logic [DATA_W-1:0]    mem_rdata_i,
  output logic                 lut_we_o,
  output logic [LUT_ID_W-1:0]  lut_id_o,
  output logic [2*COORD_W-1:0] lut_addr_o,
  output logic [DATA_W-1:0]    lut_data_o
);
  logic start, abort, busy, error, done;

  lre_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .ready_i     (!busy),
    .error_i     (error),
    .done_i      (done),
    .start_o     (start),
    .abort_o     (abort)
  );

  lre_walker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .COORD_W    (COORD_W),
    .LUT_ID_W   (LUT_ID_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .abort_i      (abort),
    .start_addr_i (reg_wdata_i),
    .busy_o       (busy),
    .error_o      (error),
    .done_o       (done),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .lut_we_o     (lut_we_o),
    .lut_id_o     (lut_id_o),
    .lut_addr_o   (lut_addr_o),
    .lut_data_o   (lut_data_o)
  );

  assign irq_o = done;
endmodule

// File: tb/lut_refill_engine_test.sv
`timescale 1ns/1ps
module lut_refill_engine_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, mem_req_o, lut_we_o;
  logic [31:0] mem_addr_o, lut_data_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [1:0]  lut_id_o;
  logic [15:0] lut_addr_o;

  always #2.5 clk = ~clk;

  lut_refill_engine uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .lut_we_o(lut_we_o), .lut_id_o(lut_id_o),
    .lut_addr_o(lut_addr_o), .lut_data_o(lut_data_o));

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [0:255];
  int log_cnt, rd_cnt, irq_cnt, exp_cnt;
  logic [15:0] log_addr [0:63];
  logic [1:0]  log_id   [0:63];
  logic [31:0] log_data [0:63];
  logic [31:0] rd_addr  [0:63];
  logic [15:0] exp_addr [0:63];
  logic [1:0]  exp_id   [0:63];
  logic [31:0] exp_data [0:63];

  // memory responder and write monitor, all at the falling edge
  initial forever begin
    @(negedge clk);
    if (lut_we_o) begin
      if (log_cnt < 64) begin
        log_addr[log_cnt] = lut_addr_o;
        log_id[log_cnt]   = lut_id_o;
        log_data[log_cnt] = lut_data_o;
      end
      log_cnt++;
    end
    if (irq_o) irq_cnt++;
    if (mem_req_o && !mem_rvalid_i) begin
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = mem[mem_addr_o[9:2]];
      if (rd_cnt < 64) rd_addr[rd_cnt] = mem_addr_o;
      rd_cnt++;
    end else begin
      mem_rvalid_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_sel_i = s; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel_i = s;
    #0.5;
    v = reg_rdata_o;
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd1, v);
      if (v[0]) break;
    end
  endtask

  task automatic clr_log();
    log_cnt = 0; rd_cnt = 0; irq_cnt = 0; exp_cnt = 0;
  endtask

  task automatic put_desc(input int a, input int x0, input int y0, input int x1, input int y1,
                          input int id, input int dptr, input int nxt);
    mem[a/4]   = 32'((y0 << 16) | x0);
    mem[a/4+1] = 32'((y1 << 16) | x1);
    mem[a/4+2] = 32'(id);
    mem[a/4+3] = 32'(dptr);
    mem[a/4+4] = 32'(nxt);
  endtask

  task automatic add_exp(input int x0, input int y0, input int x1, input int y1,
                         input int id, input int dptr);
    int n = 0;
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        if (exp_cnt < 64) begin
          exp_addr[exp_cnt] = 16'((y << 8) | x);
          exp_id[exp_cnt]   = 2'(id);
          exp_data[exp_cnt] = mem[dptr/4 + n];
        end
        exp_cnt++;
        n++;
      end
  endtask

  task automatic cmp_log(input string r);
    chk(log_cnt == exp_cnt, {r, " write count"}, 32'(log_cnt), 32'(exp_cnt));
    for (int i = 0; i < exp_cnt && i < log_cnt && i < 64; i++)
      chk(log_addr[i] == exp_addr[i] && log_id[i] == exp_id[i] && log_data[i] == exp_data[i],
          {r, " write entry"}, {log_id[i], 14'd0, log_addr[i]} ^ log_data[i],
          {exp_id[i], 14'd0, exp_addr[i]} ^ exp_data[i]);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int snap;
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + 32'(i) * 32'h0001_0203;
    clr_log();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(2'd1, v); chk(v == 32'h1, "R1 status", v, 32'h1);
    rd(2'd2, v); chk(v == 32'h0, "R1 irq status", v, 32'h0);
    chk(!mem_req_o && !lut_we_o, "R1 idle ports", {30'd0, mem_req_o, lut_we_o}, 32'h0);

    // R2 R3 R4 sweep of rectangle sizes
    for (int w = 1; w <= 3; w++)
      for (int h = 1; h <= 3; h++) begin
        int x0 = w * 5, y0 = h * 7, id = (w + 2 * h) % 4;
        int dp = 32'h200 + 32'h40 * ((w * 3 + h) % 4);
        clr_log();
        put_desc(32'h40, x0, y0, x0 + w - 1, y0 + h - 1, id, dp, 0);
        add_exp(x0, y0, x0 + w - 1, y0 + h - 1, id, dp);
        wr(2'd0, 32'h40);
        rd(2'd1, v); chk(v[0] == 1'b0, "R2 ready drops", v, 32'h0);
        wait_ready();
        cmp_log("R3 sweep");
        chk(irq_cnt == 1, "R4 irq pulse", 32'(irq_cnt), 32'd1);
        rd(2'd1, v); chk(v == 32'h1, "R4 status after done", v, 32'h1);
        if (w == 1 && h == 1)
          for (int k = 0; k < 5; k++)
            chk(rd_addr[k] == 32'h40 + 32'(4 * k), "R2 descriptor order", rd_addr[k], 32'h40 + 32'(4 * k));
        rd(2'd2, v); chk(v == 32'h1, "R4 irq status set", v, 32'h1);
        wr(2'd2, 32'h0);
        rd(2'd2, v); chk(v == 32'h1, "R10 write zero keeps", v, 32'h1);
        wr(2'd2, 32'h1);
        rd(2'd2, v); chk(v == 32'h0, "R10 write one clears", v, 32'h0);
      end
    rd(2'd0, v); chk(v == 32'h40, "R11 start address readback", v, 32'h40);

    // R4 chain of three descriptors
    clr_log();
    put_desc(32'h00, 1, 2, 2, 3, 1, 32'h200, 32'h50);
    put_desc(32'h50, 250, 0, 252, 0, 2, 32'h240, 32'h90);
    put_desc(32'h90, 7, 9, 7, 11, 3, 32'h300, 0);
    add_exp(1, 2, 2, 3, 1, 32'h200);
    add_exp(250, 0, 252, 0, 2, 32'h240);
    add_exp(7, 9, 7, 11, 3, 32'h300);
    wr(2'd0, 32'h00 + 32'h0);
    // zero would abort: use non-zero head instead
    clr_log();
    put_desc(32'h100, 1, 2, 2, 3, 1, 32'h200, 32'h50);
    add_exp(1, 2, 2, 3, 1, 32'h200);
    add_exp(250, 0, 252, 0, 2, 32'h240);
    add_exp(7, 9, 7, 11, 3, 32'h300);
    wr(2'd0, 32'h100);
    wait_ready();
    cmp_log("R4 chain");
    chk(irq_cnt == 1, "R4 single irq for chain", 32'(irq_cnt), 32'd1);
    wr(2'd2, 32'h1);

    // R9 start while busy is ignored
    clr_log();
    put_desc(32'hC0, 20, 30, 22, 32, 0, 32'h280, 0);
    add_exp(20, 30, 22, 32, 0, 32'h280);
    wr(2'd0, 32'hC0);
    wr(2'd0, 32'h100);
    wait_ready();
    cmp_log("R9 busy start");
    rd(2'd0, v); chk(v == 32'hC0, "R9 address kept", v, 32'hC0);
    wr(2'd2, 32'h1);

    // R5 misaligned start
    clr_log();
    wr(2'd0, 32'h44);
    repeat (10) @(negedge clk);
    rd(2'd1, v); chk(v == 32'h3, "R5 error and ready", v, 32'h3);
    chk(rd_cnt == 0 && log_cnt == 0 && irq_cnt == 0, "R5 no activity",
        32'(rd_cnt + log_cnt + irq_cnt), 32'd0);
    clr_log();
    put_desc(32'h40, 3, 3, 3, 3, 1, 32'h200, 0);
    wr(2'd0, 32'h40);
    wait_ready();
    rd(2'd1, v); chk(v == 32'h1, "R2 error cleared by good start", v, 32'h1);
    wr(2'd2, 32'h1);

    // R6 misaligned data pointer
    clr_log();
    put_desc(32'h40, 3, 3, 4, 4, 1, 32'h208, 0);
    wr(2'd0, 32'h40);
    wait_ready();
    rd(2'd1, v); chk(v == 32'h3, "R6 data pointer error", v, 32'h3);
    chk(log_cnt == 0 && rd_cnt == 5, "R6 stop after descriptor", 32'(log_cnt * 256 + rd_cnt), 32'd5);

    // R6 misaligned next pointer
    clr_log();
    put_desc(32'h40, 3, 3, 4, 3, 2, 32'h200, 32'h48);
    add_exp(3, 3, 4, 3, 2, 32'h200);
    wr(2'd0, 32'h40);
    wait_ready();
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk(v == 32'h3, "R6 next pointer error", v, 32'h3);
    cmp_log("R6 writes before error");
    chk(irq_cnt == 0, "R6 no irq", 32'(irq_cnt), 32'd0);

    // R7 inverted rectangle
    clr_log();
    put_desc(32'h40, 5, 3, 4, 3, 0, 32'h200, 0);
    wr(2'd0, 32'h40);
    wait_ready();
    rd(2'd1, v); chk(v == 32'h3, "R7 inverted error", v, 32'h3);
    chk(log_cnt == 0, "R7 no writes", 32'(log_cnt), 32'd0);

    // R8 abort mid-walk
    clr_log();
    put_desc(32'h40, 0, 0, 2, 2, 1, 32'h200, 0);
    wr(2'd0, 32'h40);
    for (int i = 0; i < 200 && log_cnt < 2; i++) @(negedge clk);
    wr(2'd0, 32'h0);
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk(v == 32'h1, "R8 status after abort", v, 32'h1);
    snap = log_cnt;
    repeat (30) @(negedge clk);
    chk(log_cnt == snap && snap < 9, "R8 no further writes", 32'(log_cnt), 32'(snap));
    chk(irq_cnt == 0, "R8 no irq", 32'(irq_cnt), 32'd0);
    rd(2'd3, v); chk(v == 32'h0, "R11 unused select", v, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule